// File: doc/BRIEF.md
# Synchronous Burst Address Sequencer

This block produces the word address and the per-byte write strobes that a synchronous burst SRAM array sees in each clock cycle. A cycle can do one of four things:

- Load a fresh external address. Either of two start strobes does this: one belongs to the processor side and one to the memory controller side.
- Advance an open burst by one beat.
- Hold.
- Do nothing.

Only the lowest `CNT_W` address bits are sequenced (two by default, giving four beats). The upper bits stay at the loaded value for the whole burst.

The beat order is sampled when the burst starts. It is either linear, where the low bits count up modulo the burst length from the loaded value, or interleaved, where the loaded low bits are XORed with the beat count. A new address may be loaded in every cycle, so using bursts is optional.

The write strobes are decoded once per beat. A global write enables every byte. Otherwise a byte-write enable passes through only the bytes whose select inputs are set.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is active, `mem_addr` is zero, `mem_we` is all zero and `beat_vld` is low.
- R2: When `start_cpu` or `start_ctl` is high at a clock edge, `mem_addr` equals the `ext_addr` sampled at that edge, and `beat_vld` is high after that edge.
- R3: In linear order (`order_ilv` low at the start), each cycle with only `advance` high sets the low `CNT_W` bits to the loaded low bits plus the beat count, modulo 2^`CNT_W`. This step also raises `beat_vld`.
- R4: In interleaved order (`order_ilv` high at the start), the low bits are the loaded low bits XOR the beat count.
- R5: `order_ilv` is sampled only in a start cycle; changing it during a burst has no effect on the sequence.
- R6: In a cycle with no start and no `advance`, `mem_addr` holds its value, `beat_vld` is low and `mem_we` is all zero.
- R7: After 2^`CNT_W` advances the address returns to the loaded start beat, and the bits above the low `CNT_W` never change during advances.
- R8: If both start strobes are high together, `start_cpu` wins: the address is loaded and the cycle is a read, so `mem_we` is all zero even with `wr_all` high.
- R9: In a write beat (a `start_ctl` start without `start_cpu`, or an advance) with `wr_all` low, `mem_we` equals `wr_byte_sel` when `wr_byte_en` is high and is all zero when it is low. Bit i of `mem_we` is byte i.
- R10: In a write beat with `wr_all` high, `mem_we` is all ones, whatever `wr_byte_en` and `wr_byte_sel` are.
- R11: Back-to-back start cycles each load their own address, with no idle cycle in between.
- R12: A start by `start_cpu` alone is a read beat: `mem_we` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_addr | input | ADDR_W | External address loaded at a burst start |
| start_cpu | input | 1 | Processor-side burst start; read, and wins over start_ctl |
| start_ctl | input | 1 | Controller-side burst start; may carry a write |
| advance | input | 1 | Steps the open burst by one beat |
| order_ilv | input | 1 | Beat order at start: 0 linear, 1 interleaved |
| wr_all | input | 1 | Global write: all bytes |
| wr_byte_en | input | 1 | Byte-write enable |
| wr_byte_sel | input | NBYTES | Per-byte select, bit i is byte i |
| mem_addr | output | ADDR_W | Current internal array address |
| mem_we | output | NBYTES | Per-byte write enables for this beat |
| beat_vld | output | 1 | A beat is issued this cycle |

## Verification
Two decisions can land in the same cycle: the choice between the two start strobes, and the choice between the global write and the byte-level selects. The bench raises both start strobes together with `wr_all` high. It expects a loaded address with all-zero strobes, because the processor-side read must win over both the controller start and the global write. It also raises `wr_all` together with a disabled or partial byte selection in a controller start and in an advance, and expects every byte enabled. A scoreboard model built from the requirements predicts each cycle's address and strobes.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

   typedef enum logic [1:0] {
      CYC_IDLE        = 2'd0,
      CYC_READ_START  = 2'd1,
      CYC_WRITE_START = 2'd2,
      CYC_ADVANCE     = 2'd3
   } cyc_e;

   // processor strobe has priority and always reads
   function automatic cyc_e classify(input logic s_cpu, input logic s_ctl, input logic adv);
      if (s_cpu)      return CYC_READ_START;
      else if (s_ctl) return CYC_WRITE_START;
      else if (adv)   return CYC_ADVANCE;
      else            return CYC_IDLE;
   endfunction

   function automatic logic is_start(input cyc_e c);
      return (c == CYC_READ_START) || (c == CYC_WRITE_START);
   endfunction

   function automatic logic is_write_beat(input cyc_e c);
      return (c == CYC_WRITE_START) || (c == CYC_ADVANCE);
   endfunction

endpackage

// File: rtl/bsq_ctrl.sv
module bsq_ctrl
   import burst_seq_pkg::*;
#(
   parameter int ADDR_W = 20,
   parameter int CNT_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  cyc_e              cyc,
   input  logic [ADDR_W-1:0] ext_addr,
   input  logic              order_in,
   output logic [ADDR_W-1:0] base_q,
   output logic [CNT_W-1:0]  cnt_q,
   output logic              ilv_q,
   output logic              vld_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         cnt_q  <= '0;
         ilv_q  <= 1'b0;
         vld_q  <= 1'b0;
      end else begin
         vld_q <= (cyc != CYC_IDLE);
         if (is_start(cyc)) begin
            base_q <= ext_addr;
            cnt_q  <= '0;
            ilv_q  <= order_in;
         end else if (cyc == CYC_ADVANCE) begin
            cnt_q <= cnt_q + 1'b1;   // natural wrap at 2**CNT_W
         end
      end
   end

endmodule

// File: rtl/bsq_order.sv
module bsq_order #(
   parameter int CNT_W     = 2,
   parameter bit ALLOW_ILV = 1'b1
) (
   input  logic [CNT_W-1:0] base_low,
   input  logic [CNT_W-1:0] cnt,
   input  logic             ilv,
   output logic [CNT_W-1:0] low
);

   logic [CNT_W-1:0] lin_low;
   assign lin_low = base_low + cnt;

   generate
      if (ALLOW_ILV) begin : g_both
         assign low = ilv ? (base_low ^ cnt) : lin_low;
      end else begin : g_lin_only
         logic unused_ilv;
         assign unused_ilv = ilv;
         assign low        = lin_low;
      end
   endgenerate

endmodule

// File: rtl/bsq_wdec.sv
module bsq_wdec
   import burst_seq_pkg::*;
#(
   parameter int NBYTES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  cyc_e              cyc,
   input  logic              wr_all,
   input  logic              wr_byte_en,
   input  logic [NBYTES-1:0] wr_byte_sel,
   output logic [NBYTES-1:0] we_q
);

   logic wbeat;
   assign wbeat = is_write_beat(cyc);

   for (genvar b = 0; b < NBYTES; b++) begin : g_lane
      logic lane_d;
      assign lane_d = wbeat & (wr_all | (wr_byte_en & wr_byte_sel[b]));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) we_q[b] <= 1'b0;
         else        we_q[b] <= lane_d;
      end
   end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
   import burst_seq_pkg::*;
#(
   parameter int ADDR_W    = 20,
   parameter int NBYTES    = 2,
   parameter int CNT_W     = 2,
   parameter bit ALLOW_ILV = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] ext_addr,
   input  logic              start_cpu,
   input  logic              start_ctl,
   input  logic              advance,
   input  logic              order_ilv,
   input  logic              wr_all,
   input  logic              wr_byte_en,
   input  logic [NBYTES-1:0] wr_byte_sel,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [NBYTES-1:0] mem_we,
   output logic              beat_vld
);

   localparam int HI_W = ADDR_W - CNT_W;

   generate
      if (CNT_W < 1 || CNT_W >= ADDR_W) begin : g_bad_cnt
         $error("CNT_W must be in 1..ADDR_W-1");
      end
      if (NBYTES < 1) begin : g_bad_nb
         $error("NBYTES must be at least 1");
      end
   endgenerate

   cyc_e              cyc;
   logic [ADDR_W-1:0] base_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              ilv_q;
   logic [CNT_W-1:0]  low;

   assign cyc = classify(start_cpu, start_ctl, advance);

   bsq_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .cyc     (cyc),
      .ext_addr(ext_addr),
      .order_in(order_ilv),
      .base_q  (base_q),
      .cnt_q   (cnt_q),
      .ilv_q   (ilv_q),
      .vld_q   (beat_vld)
   );

   bsq_order #(.CNT_W(CNT_W), .ALLOW_ILV(ALLOW_ILV)) i_order (
      .base_low(base_q[CNT_W-1:0]),
      .cnt     (cnt_q),
      .ilv     (ilv_q),
      .low     (low)
   );

   bsq_wdec #(.NBYTES(NBYTES)) i_wdec (
      .clk        (clk),
      .rst_n      (rst_n),
      .cyc        (cyc),
      .wr_all     (wr_all),
      .wr_byte_en (wr_byte_en),
      .wr_byte_sel(wr_byte_sel),
      .we_q       (mem_we)
   );

   logic [HI_W-1:0] hi;
   assign hi       = base_q[ADDR_W-1:CNT_W];
   assign mem_addr = {hi, low};

endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
   parameter int ADDR_W = 20,
   parameter int NBYTES = 2,
   parameter int CNT_W  = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] ext_addr,
   input logic              start_cpu,
   input logic              start_ctl,
   input logic              advance,
   input logic              wr_all,
   input logic              wr_byte_en,
   input logic [NBYTES-1:0] wr_byte_sel,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [NBYTES-1:0] mem_we,
   input logic              beat_vld
);

   logic start_any, adv_only, wbeat;
   assign start_any = start_cpu | start_ctl;
   assign adv_only  = advance & ~start_any;
   assign wbeat     = (start_ctl & ~start_cpu) | adv_only;

   always_comb begin
      if (!rst_n) begin
         a_reset_r1: assert (mem_addr == '0 && mem_we == '0 && !beat_vld);
      end
   end

   p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      start_any |=> (mem_addr == $past(ext_addr)) && beat_vld);

   p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!start_any && !advance) |=> !beat_vld && mem_we == '0 && $stable(mem_addr));

   p_upper_r7: assert property (@(posedge clk) disable iff (!rst_n)
      adv_only |=> mem_addr[ADDR_W-1:CNT_W] == $past(mem_addr[ADDR_W-1:CNT_W]));

   p_cpu_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
      start_cpu |=> mem_we == '0);

   p_byte_sel_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wbeat && !wr_all) |=> mem_we == ($past(wr_byte_en) ? $past(wr_byte_sel) : '0));

   p_global_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wbeat && wr_all) |=> mem_we == {NBYTES{1'b1}});

endmodule

bind burst_addr_seq burst_addr_seq_chk #(
   .ADDR_W(ADDR_W), .NBYTES(NBYTES), .CNT_W(CNT_W)
) i_chk (
   .clk(clk), .rst_n(rst_n), .ext_addr(ext_addr), .start_cpu(start_cpu),
   .start_ctl(start_ctl), .advance(advance), .wr_all(wr_all),
   .wr_byte_en(wr_byte_en), .wr_byte_sel(wr_byte_sel), .mem_addr(mem_addr),
   .mem_we(mem_we), .beat_vld(beat_vld)
);

// File: tb/test_burst_addr_seq.sv
module test_burst_addr_seq;

   localparam int AW = 20;
   localparam int NB = 2;
   localparam int CW = 2;

   typedef struct {
      logic [AW-1:0] addr;
      logic [NB-1:0] we;
      logic          vld;
      string         req;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] ext_addr = '0;
   logic          start_cpu = 1'b0, start_ctl = 1'b0, advance = 1'b0, order_ilv = 1'b0;
   logic          wr_all = 1'b0, wr_byte_en = 1'b0;
   logic [NB-1:0] wr_byte_sel = '0;
   logic [AW-1:0] mem_addr;
   logic [NB-1:0] mem_we;
   logic          beat_vld;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;
   exp_t q[$];

   logic [AW-1:0] m_base = '0;
   logic [CW-1:0] m_cnt  = '0;
   logic          m_ilv  = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   burst_addr_seq #(.ADDR_W(AW), .NBYTES(NB), .CNT_W(CW)) i_burst_addr_seq (
      .clk(clk), .rst_n(rst_n), .ext_addr(ext_addr), .start_cpu(start_cpu),
      .start_ctl(start_ctl), .advance(advance), .order_ilv(order_ilv),
      .wr_all(wr_all), .wr_byte_en(wr_byte_en), .wr_byte_sel(wr_byte_sel),
      .mem_addr(mem_addr), .mem_we(mem_we), .beat_vld(beat_vld)
   );

   function automatic logic [AW-1:0] model_addr();
      logic [CW-1:0] lo;
      lo = m_ilv ? (m_base[CW-1:0] ^ m_cnt) : (m_base[CW-1:0] + m_cnt);
      return {m_base[AW-1:CW], lo};
   endfunction

   task automatic drive(input logic cpu, input logic ctl, input logic adv,
                        input logic ord, input logic gw, input logic bwe,
                        input logic [NB-1:0] sel, input logic [AW-1:0] a,
                        input string req);
      exp_t e;
      @(negedge clk);
      start_cpu = cpu; start_ctl = ctl; advance = adv; order_ilv = ord;
      wr_all = gw; wr_byte_en = bwe; wr_byte_sel = sel; ext_addr = a;
      if (cpu || ctl) begin
         m_base = a; m_cnt = '0; m_ilv = ord;
      end else if (adv) begin
         m_cnt = m_cnt + 1'b1;
      end
      e.addr = model_addr();
      e.vld  = cpu | ctl | adv;
      if (cpu || !(ctl || adv)) e.we = '0;
      else if (gw)              e.we = '1;
      else if (bwe)             e.we = sel;
      else                      e.we = '0;
      e.req = req;
      q.push_back(e);
   endtask

   initial begin : monitor
      exp_t e;
      forever begin
         @(posedge clk);
         #1;
         if (q.size() > 0) begin
            e = q.pop_front();
            total++;
            if (mem_addr !== e.addr || mem_we !== e.we || beat_vld !== e.vld) begin
               bad++;
               $display("FAIL %s: addr=%h we=%b vld=%b expected addr=%h we=%b vld=%b",
                        e.req, mem_addr, mem_we, beat_vld, e.addr, e.we, e.vld);
            end
         end
      end
   end

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog: run hung, expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : stim
      repeat (3) @(posedge clk);
      #5;
      total++;   // R1 reset state
      if (mem_addr !== '0 || mem_we !== '0 || beat_vld !== 1'b0) begin
         bad++;
         $display("FAIL R1: addr=%h we=%b vld=%b expected 0 0 0", mem_addr, mem_we, beat_vld);
      end
      @(negedge clk) rst_n = 1'b1;

      // R2/R9: controller start, linear, byte 0 only
      drive(0,1,0, 0, 0,1,2'b01, 20'h12345, "R2");
      // R3: linear advances, no write
      drive(0,0,1, 0, 0,0,2'b11, 20'h0, "R3");
      drive(0,0,1, 0, 0,0,2'b00, 20'h0, "R3");
      drive(0,0,1, 0, 0,1,2'b10, 20'h0, "R3");
      // R7: fourth advance wraps to start beat
      drive(0,0,1, 0, 0,0,2'b00, 20'hFFFFF, "R7");
      // R6: idle holds, no beat
      drive(0,0,0, 1, 1,1,2'b11, 20'hFFFFF, "R6");
      // R10: global write in an advance
      drive(0,0,1, 0, 1,0,2'b00, 20'h0, "R10");
      // R12: processor start is a read even with global write, interleaved
      drive(1,0,0, 1, 1,1,2'b11, 20'h0ABCE, "R12");
      // R4/R5: interleaved advances while order input is toggled
      drive(0,0,1, 0, 0,0,2'b00, 20'h0, "R4");
      drive(0,0,1, 1, 0,0,2'b00, 20'h0, "R5");
      drive(0,0,1, 0, 0,0,2'b00, 20'h0, "R4");
      drive(0,0,1, 0, 0,0,2'b00, 20'h0, "R7");
      // R8: both strobes, processor wins, read
      drive(1,1,0, 0, 1,1,2'b11, 20'h55557, "R8");
      // R11: back-to-back loads with byte writes (R9)
      drive(0,1,0, 0, 0,1,2'b10, 20'h00001, "R11");
      drive(0,1,0, 1, 0,1,2'b01, 20'hFEDC2, "R11");
      drive(0,1,0, 0, 0,1,2'b11, 20'h3C3C3, "R11");
      // R10: global write overrides cleared byte enable
      drive(0,1,0, 0, 1,0,2'b00, 20'h0F0F0, "R10");
      // R9: byte enable low blocks selects
      drive(0,1,0, 0, 0,0,2'b11, 20'h44444, "R9");
      drive(0,0,0, 0, 0,0,2'b00, 20'h0, "R6");

      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule